// File: doc/BRIEF.md
# DMA External Bus Hold Arbiter

This block arbitrates ownership of the external memory bus between the on-chip DMA engine and an outside master. Each role has its own enable bit. In the serving role (`serve_en`), an outside master asks for the bus on the hold line. The block answers on the acknowledge line, and while that request stays active it keeps the DMA engine from starting any transfer that touches external memory. In the claiming role (`claim_en`), the block itself raises the hold line before an external DMA transfer. It holds the start strobe back until an acknowledge comes back.

The DMA engine presents `xfer_req` together with `xfer_ext`, which says whether the transfer targets external memory. It keeps both steady until it sees `xfer_go`, and it ends an external transfer with a one-cycle `xfer_done`. Internal transfers never wait. Both incoming pins pass through a synchronizer of `SYNC_STAGES` flops before the state machine sees them.

The state machine has five states. IDLE means no external transfer is in flight and the bus is not lent. CLAIM means the hold line is driven and the block waits for the acknowledge. HELD_XFER is an external transfer running under the block's own hold. OWN_XFER is an external transfer running with claiming disabled. GRANT means the acknowledge is driven to an outside master.

The transitions are:
- IDLE to GRANT on a pending served hold.
- IDLE to CLAIM on an external request when claiming is enabled.
- IDLE to OWN_XFER on an external request when claiming is disabled.
- CLAIM to HELD_XFER on a synchronized acknowledge.
- CLAIM to IDLE when the request is withdrawn.
- HELD_XFER to IDLE on `xfer_done`.
- OWN_XFER to GRANT on `xfer_done` when a served hold is pending.
- OWN_XFER to IDLE on `xfer_done` otherwise.
- GRANT to IDLE when the synchronized hold goes low.

Top module: `dma_hold_arbiter`

## Requirements
- R1: After reset, `hold_pin_out`, `ack_pin_out` and `xfer_go` are 0 while `xfer_req` is 0.
- R2: With `serve_en`=1 and the block idle, `ack_pin_out` rises on the (SYNC_STAGES+1)-th rising clock edge after `hold_pin_in` goes high, and not earlier.
- R3: With `serve_en`=0, `ack_pin_out` never asserts, whatever `hold_pin_in` does.
- R4: While `ack_pin_out` is high and the synchronized hold is still active, `xfer_go` is never given to a request with `xfer_ext`=1.
- R5: `ack_pin_out` drops on the (SYNC_STAGES+1)-th rising edge after `hold_pin_in` goes low, that is, one cycle after the synchronized hold goes inactive.
- R6: With `claim_en`=1, an idle external request raises `hold_pin_out` on the next edge, and `xfer_go` stays 0 until the acknowledge has passed the synchronizer (SYNC_STAGES edges after `ack_pin_in` rises).
- R7: `hold_pin_out` goes low on the rising edge that samples `xfer_done`=1 in HELD_XFER. A request withdrawn in CLAIM also releases the line on the next edge.
- R8: With `claim_en`=0 and the block idle with no served hold pending, an external request receives `xfer_go` in the same cycle, and `hold_pin_out` stays 0.
- R9: A request with `xfer_ext`=0 receives `xfer_go` in the same cycle, in every state and under every mode setting.
- R10: A served hold that arrives during an external transfer is granted only at the transfer boundary, on the edge that samples `xfer_done`.
- R11: With both roles enabled, a served hold and a new external request seen in the same cycle resolve to GRANT first. The hold line is raised only after the grant ends.
- R12: `hold_pin_out` and `ack_pin_out` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| serve_en | input | 1 | Enables the serving role (answer outside hold requests) |
| claim_en | input | 1 | Enables the claiming role (request the bus before external DMA) |
| hold_pin_in | input | 1 | Hold request from an outside master, asynchronous |
| ack_pin_in | input | 1 | Acknowledge from the outside arbiter, asynchronous |
| hold_pin_out | output | 1 | Hold request driven by this block |
| ack_pin_out | output | 1 | Acknowledge driven to an outside master |
| xfer_req | input | 1 | DMA engine wants to start a transfer |
| xfer_ext | input | 1 | The requested transfer targets external memory |
| xfer_done | input | 1 | One-cycle pulse ending an external transfer |
| xfer_go | output | 1 | Start strobe to the DMA engine |

## Verification
The bench builds the block with SYNC_STAGES=3 rather than the default 2. Every pin latency therefore differs from a hard-coded two-flop delay, and an off-by-one in the synchronizer chain or in the GRANT entry and exit shows up in the R2 and R5 edge counts. The extra stage also leaves room to probe the acknowledge one edge before it can legally arrive in CLAIM. That room separates a premature start strobe from a correct one.

// File: rtl/dha_pkg.sv
package dha_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_CLAIM     = 3'd1,
        ST_OWN_XFER  = 3'd2,
        ST_HELD_XFER = 3'd3,
        ST_GRANT     = 3'd4
    } dha_state_t;

endpackage

// File: rtl/dha_sync.sv
module dha_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= din;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= chain[s-1];
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/dha_fsm.sv
module dha_fsm
    import dha_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic serve_en,
    input  logic claim_en,
    input  logic hold_seen,
    input  logic ack_seen,
    input  logic xfer_req,
    input  logic xfer_ext,
    input  logic xfer_done,
    output logic hold_drive,
    output logic ack_drive,
    output logic xfer_go
);

    dha_state_t state, state_nx;
    logic serve_pend, ext_req, ext_go;

    assign serve_pend = serve_en & hold_seen;
    assign ext_req    = xfer_req & xfer_ext;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (serve_pend)   state_nx = ST_GRANT;
                else if (ext_req) state_nx = claim_en ? ST_CLAIM : ST_OWN_XFER;
            end
            ST_CLAIM: begin
                if (!ext_req)      state_nx = ST_IDLE;
                else if (ack_seen) state_nx = ST_HELD_XFER;
            end
            ST_OWN_XFER: begin
                if (xfer_done) state_nx = serve_pend ? ST_GRANT : ST_IDLE;
            end
            ST_HELD_XFER: begin
                if (xfer_done) state_nx = ST_IDLE;
            end
            ST_GRANT: begin
                if (!hold_seen) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        hold_drive = 1'b0;
        ack_drive  = 1'b0;
        ext_go     = 1'b0;
        unique case (state)
            ST_IDLE:      ext_go     = ext_req & ~serve_pend & ~claim_en;
            ST_CLAIM: begin
                hold_drive = 1'b1;
                ext_go     = ext_req & ack_seen;
            end
            ST_HELD_XFER: hold_drive = 1'b1;
            ST_GRANT:     ack_drive  = 1'b1;
            ST_OWN_XFER:  ext_go     = 1'b0;
            default:      ext_go     = 1'b0;
        endcase
        xfer_go = ext_go | (xfer_req & ~xfer_ext);
    end

    a_r3_no_ack_when_serving_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!serve_en && !ack_drive) |=> !ack_drive);

    a_r4_no_ext_start_during_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_drive && hold_seen) |-> !(xfer_go && xfer_ext));

    a_r6_ext_start_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_go && xfer_ext && hold_drive) |-> ack_seen);

    a_r7_release_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HELD_XFER && xfer_done) |=> !hold_drive);

    a_r9_internal_never_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_ext) |-> xfer_go);

    a_r12_lines_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(hold_drive && ack_drive));

endmodule

// File: rtl/dma_hold_arbiter.sv
module dma_hold_arbiter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic serve_en,
    input  logic claim_en,
    input  logic hold_pin_in,
    input  logic ack_pin_in,
    output logic hold_pin_out,
    output logic ack_pin_out,
    input  logic xfer_req,
    input  logic xfer_ext,
    input  logic xfer_done,
    output logic xfer_go
);

    localparam int PIN_COUNT = 2;

    logic [PIN_COUNT-1:0] pins_raw, pins_seen;

    assign pins_raw = {ack_pin_in, hold_pin_in};

    dha_sync #(
        .WIDTH (PIN_COUNT),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pins_raw),
        .dout (pins_seen)
    );

    dha_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .serve_en  (serve_en),
        .claim_en  (claim_en),
        .hold_seen (pins_seen[0]),
        .ack_seen  (pins_seen[1]),
        .xfer_req  (xfer_req),
        .xfer_ext  (xfer_ext),
        .xfer_done (xfer_done),
        .hold_drive(hold_pin_out),
        .ack_drive (ack_pin_out),
        .xfer_go   (xfer_go)
    );

endmodule

// File: tb/dma_hold_arbiter_test.sv
`timescale 1ns/1ps
module dma_hold_arbiter_test;

    localparam int S = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic serve_en = 1'b0, claim_en = 1'b0;
    logic hold_pin_in = 1'b0, ack_pin_in = 1'b0;
    logic xfer_req = 1'b0, xfer_ext = 1'b0, xfer_done = 1'b0;
    logic hold_pin_out, ack_pin_out, xfer_go;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dma_hold_arbiter #(.SYNC_STAGES(S)) uut (
        .clk(clk), .rst_n(rst_n),
        .serve_en(serve_en), .claim_en(claim_en),
        .hold_pin_in(hold_pin_in), .ack_pin_in(ack_pin_in),
        .hold_pin_out(hold_pin_out), .ack_pin_out(ack_pin_out),
        .xfer_req(xfer_req), .xfer_ext(xfer_ext), .xfer_done(xfer_done),
        .xfer_go(xfer_go)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle;
        xfer_req = 0; xfer_ext = 0; xfer_done = 0;
        hold_pin_in = 0; ack_pin_in = 0;
        tick(S + 3);
    endtask

    task automatic t_reset;
        tick(2);
        chk("R1 hold after reset", hold_pin_out, 1'b0);
        chk("R1 ack after reset", ack_pin_out, 1'b0);
        chk("R1 go after reset", xfer_go, 1'b0);
    endtask

    task automatic t_serve;
        serve_en = 1; claim_en = 0;
        hold_pin_in = 1;
        tick(S);
        chk("R2 ack not before S+1 edges", ack_pin_out, 1'b0);
        tick(1);
        chk("R2 ack after S+1 edges", ack_pin_out, 1'b1);
        xfer_req = 1; xfer_ext = 1; #1;
        chk("R4 ext blocked in grant", xfer_go, 1'b0);
        tick(3);
        chk("R4 ext still blocked", xfer_go, 1'b0);
        xfer_ext = 0; #1;
        chk("R9 internal passes in grant", xfer_go, 1'b1);
        xfer_req = 0;
        hold_pin_in = 0;
        tick(S);
        chk("R5 ack held until synced drop", ack_pin_out, 1'b1);
        tick(1);
        chk("R5 ack dropped", ack_pin_out, 1'b0);
        chk("R12 no hold in grant path", hold_pin_out, 1'b0);
        settle();
    endtask

    task automatic t_serve_off;
        serve_en = 0; claim_en = 0;
        hold_pin_in = 1;
        tick(S + 4);
        chk("R3 no ack when serving off", ack_pin_out, 1'b0);
        xfer_req = 1; xfer_ext = 1; #1;
        chk("R8 ext go without claim", xfer_go, 1'b1);
        chk("R8 hold stays low", hold_pin_out, 1'b0);
        tick(1);
        xfer_req = 0; xfer_ext = 0;
        xfer_done = 1;
        tick(1);
        xfer_done = 0;
        chk("R3 still no ack", ack_pin_out, 1'b0);
        settle();
    endtask

    task automatic t_claim;
        serve_en = 0; claim_en = 1;
        xfer_req = 1; xfer_ext = 1; #1;
        chk("R6 no go before hold", xfer_go, 1'b0);
        tick(1);
        chk("R6 hold raised next edge", hold_pin_out, 1'b1);
        chk("R6 go withheld", xfer_go, 1'b0);
        ack_pin_in = 1;
        tick(S - 1);
        chk("R6 go withheld before synced ack", xfer_go, 1'b0);
        tick(1);
        chk("R6 go after synced ack", xfer_go, 1'b1);
        tick(1);
        xfer_req = 0; xfer_ext = 0;
        chk("R7 hold kept during transfer", hold_pin_out, 1'b1);
        xfer_done = 1; #1;
        chk("R7 hold up on done cycle", hold_pin_out, 1'b1);
        tick(1);
        xfer_done = 0;
        chk("R7 hold released after done", hold_pin_out, 1'b0);
        settle();
        xfer_req = 1; xfer_ext = 1;
        tick(1);
        chk("R7 hold raised for withdrawn request", hold_pin_out, 1'b1);
        xfer_req = 0;
        tick(1);
        chk("R7 hold released on withdraw", hold_pin_out, 1'b0);
        settle();
    endtask

    task automatic t_boundary;
        serve_en = 1; claim_en = 0;
        xfer_req = 1; xfer_ext = 1; #1;
        chk("R8 idle ext go", xfer_go, 1'b1);
        tick(1);
        xfer_req = 0; xfer_ext = 0;
        hold_pin_in = 1;
        tick(S + 3);
        chk("R10 no grant mid-transfer", ack_pin_out, 1'b0);
        xfer_done = 1;
        tick(1);
        xfer_done = 0;
        chk("R10 grant at boundary", ack_pin_out, 1'b1);
        settle();
        chk("R10 grant released", ack_pin_out, 1'b0);
    endtask

    task automatic t_priority;
        serve_en = 1; claim_en = 1;
        hold_pin_in = 1;
        tick(S);
        xfer_req = 1; xfer_ext = 1; #1;
        chk("R11 no go with pending hold", xfer_go, 1'b0);
        tick(1);
        chk("R11 grant served first", ack_pin_out, 1'b1);
        chk("R11 hold not raised", hold_pin_out, 1'b0);
        hold_pin_in = 0;
        tick(S + 1);
        chk("R11 grant ended", ack_pin_out, 1'b0);
        chk("R12 hold low at grant end", hold_pin_out, 1'b0);
        tick(1);
        chk("R11 hold raised after grant", hold_pin_out, 1'b1);
        chk("R12 ack low while claiming", ack_pin_out, 1'b0);
        settle();
    endtask

    initial begin
        tick(3);
        rst_n = 1;
        t_reset();
        t_serve();
        t_serve_off();
        t_claim();
        t_boundary();
        t_priority();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule